// File: doc/BRIEF.md
# Block-Gap Transfer Pause Controller

This controller decides where a multi-block card data transfer stops and starts again. Software sets a stop-at-gap bit and a continue bit. The controller only acts on them at the boundary between two blocks, so a block that is already being shifted always completes. The data path reports each block end with a strobe and supplies the number of blocks still to go, which includes the block that is ending. From these inputs the controller drives the run enable for the shifter and the card clock enable. On reads it can also drive a read-wait request onto the data line.

How a pause is held depends on the direction and on the read-wait bit:

- On a read with read-wait enabled, the controller asserts the read-wait drive, so the card holds off by itself.
- On a read with read-wait disabled, the controller gates the card clock off instead.
- On a write, the clock keeps running and the controller simply stops issuing blocks.

The controller also:

- opens a window for sampling card interrupts in the gaps between blocks, but only on a 4-bit bus;
- rejects host writes into the data register while a stop is requested;
- emits a one-cycle completion pulse when the last block ends.

Top module: `gap_pause_ctrl`

## Requirements
- R1: After reset `run`, `busy`, `read_wait_drv`, `irq_window`, `xfer_done` and `cont_bit` are 0, and `clk_en` is 1.
- R2: A `start` pulse while idle raises `run` on the next cycle. It also latches `dir_read` (1 = read, 0 = write) for the whole transfer. `busy` is 1 while a transfer is running and during its completion cycle.
- R3: `run` never falls except on the cycle after a `blk_end` strobe. A stop request raised in the middle of a block does not cut that block short.
- R4: A `blk_end` with `stop_req` set and `blk_remain` greater than 1 pauses the transfer. On a read with `rw_en` = 0 the pause drives `clk_en` to 0. On a write `clk_en` stays 1.
- R5: On a read with `rw_en` = 1, the same pause raises `read_wait_drv` on the cycle after the block ends, and `clk_en` stays 1.
- R6: A paused transfer resumes on the cycle after `cont_bit` is 1 while `stop_req` is 0. While `stop_req` is 1 the transfer stays paused, even with `cont_bit` set.
- R7: `cont_bit` is set by a `cont_set` pulse. It clears by itself on the edge at which the transfer resumes, so it reads 0 on the first cycle that `busy` is back at 1. A `cont_set` on that same edge wins over the clear.
- R8: `irq_window` is 1 only when `gap_irq_en` = 1 and `bus_4bit` = 1 (1 = 4-bit, 0 = 1-bit). Under those conditions it is 1 for one cycle after each non-final `blk_end`, and for the whole of a pause. On a 1-bit bus it stays 0.
- R9: A `blk_end` with `blk_remain` of 1 or 0 produces a one-cycle `xfer_done` on the following cycle, whatever `stop_req` is. The controller is idle on the cycle after that.
- R10: `wr_accept` follows `data_wr` only while `stop_req` is 0. A data register write made with `stop_req` at 1 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_read | input | 1 | 1 = read transfer, 0 = write transfer |
| bus_4bit | input | 1 | 1 = 4-bit bus, 0 = 1-bit bus |
| stop_req | input | 1 | Stop at the next block gap |
| cont_set | input | 1 | Host write pulse that sets the continue bit |
| rw_en | input | 1 | Read-wait enable |
| gap_irq_en | input | 1 | Enable interrupt sampling in block gaps |
| blk_end | input | 1 | End-of-block strobe from the data path |
| blk_remain | input | CNT_W | Blocks left, counting the one ending |
| data_wr | input | 1 | Host attempt to write the data register |
| run | output | 1 | Data path may shift blocks |
| busy | output | 1 | Transfer in progress |
| clk_en | output | 1 | Card clock enable |
| read_wait_drv | output | 1 | Drive read-wait onto the data line |
| irq_window | output | 1 | Gap interrupt sampling window |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| cont_bit | output | 1 | Continue bit, self-clearing |
| wr_accept | output | 1 | Data register write accepted |

## Verification
The bench raises a stop request in the middle of a block, because a design that stopped on the request itself would drop `run` before the block finished. It sets the continue bit while the stop bit is still high: a design that ignored that interlock would resume too early. It then checks that the continue bit has already cleared on the first busy cycle, since a design that kept it set would skip straight past the next pause. The last block ends while a stop is still pending, which catches a design that pauses instead of completing. The bench also runs a read pause with read-wait both on and off, and a 1-bit bus with gap interrupts enabled. These expose swapped read-wait and clock gating, and an interrupt window that ignores the bus width.

// File: rtl/gap_pause_ctrl.sv
module gap_pause_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_read,
  input  logic             bus_4bit,
  input  logic             stop_req,
  input  logic             cont_set,
  input  logic             rw_en,
  input  logic             gap_irq_en,
  input  logic             blk_end,
  input  logic [CNT_W-1:0] blk_remain,
  input  logic             data_wr,
  output logic             run,
  output logic             busy,
  output logic             clk_en,
  output logic             read_wait_drv,
  output logic             irq_window,
  output logic             xfer_done,
  output logic             cont_bit,
  output logic             wr_accept
);
  typedef enum logic [2:0] {ST_IDLE, ST_XFER, ST_GAP, ST_RDWAIT, ST_DONE} st_t;

  st_t  st, st_nx;
  logic dir_q, gap_q, cont_q;

  wire last_blk = blk_remain <= CNT_W'(1);
  wire paused   = (st == ST_GAP) || (st == ST_RDWAIT);
  wire resume   = paused && cont_q && !stop_req;
  wire mid_gap  = (st == ST_XFER) && blk_end && !last_blk;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (start) st_nx = ST_XFER;
      ST_XFER:   if (blk_end) begin
                   if (last_blk)      st_nx = ST_DONE;
                   else if (stop_req) st_nx = (dir_q && rw_en) ? ST_RDWAIT : ST_GAP;
                 end
      ST_GAP,
      ST_RDWAIT: if (resume) st_nx = ST_XFER;
      ST_DONE:   st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      dir_q  <= 1'b0;
      gap_q  <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      st    <= st_nx;
      gap_q <= mid_gap;
      if (st == ST_IDLE && start) dir_q <= dir_read;
      if (cont_set)    cont_q <= 1'b1;
      else if (resume) cont_q <= 1'b0;
    end
  end

  assign run           = st == ST_XFER;
  assign busy          = (st == ST_XFER) || (st == ST_DONE);
  assign clk_en        = !((st == ST_GAP) && dir_q);
  assign read_wait_drv = st == ST_RDWAIT;
  assign irq_window    = gap_irq_en && bus_4bit && (gap_q || paused);
  assign xfer_done     = st == ST_DONE;
  assign cont_bit      = cont_q;
  assign wr_accept     = data_wr && !stop_req;
endmodule

module gap_pause_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic blk_end,
  input logic paused,
  input logic stop_req,
  input logic cont_set,
  input logic cont_bit,
  input logic read_wait_drv,
  input logic xfer_done,
  input logic bus_4bit,
  input logic irq_window
);
  AST_RUN_HOLDS_MID_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !blk_end) |=> run); // R3
  AST_RDWAIT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_wait_drv) |-> $past(blk_end)); // R5
  AST_STOP_HOLDS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && stop_req) |=> !run); // R6
  AST_CONT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && cont_bit && !stop_req && !cont_set) |=> (run && !cont_bit)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R9
  AST_NO_IRQ_1BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_4bit |-> !irq_window); // R8
endmodule

bind gap_pause_ctrl gap_pause_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .blk_end(blk_end), .paused(paused),
  .stop_req(stop_req), .cont_set(cont_set), .cont_bit(cont_bit),
  .read_wait_drv(read_wait_drv), .xfer_done(xfer_done),
  .bus_4bit(bus_4bit), .irq_window(irq_window)
);

// File: tb/gap_pause_ctrl_tb.sv
module gap_pause_ctrl_tb;
  localparam int CNT_W = 16;
  logic clk = 0, rst_n = 0;
  logic start = 0, dir_read = 0, bus_4bit = 1, stop_req = 0, cont_set = 0;
  logic rw_en = 0, gap_irq_en = 0, blk_end = 0, data_wr = 0;
  logic [CNT_W-1:0] blk_remain = '0;
  logic run, busy, clk_en, read_wait_drv, irq_window, xfer_done, cont_bit, wr_accept;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  gap_pause_ctrl #(.CNT_W(CNT_W)) u_dut (.*);

  // reference model: 0 idle, 1 moving, 2 paused with clock or plain, 3 read-wait, 4 complete
  int m_st = 0;
  bit m_dir = 0, m_gap = 0, m_cont = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int nst;
    bit paused_m, resume_m;
    if (!rst_n) begin
      m_st = 0; m_dir = 0; m_gap = 0; m_cont = 0;
    end else begin
      paused_m = (m_st == 2) || (m_st == 3);
      resume_m = paused_m && m_cont && !stop_req;
      nst = m_st;
      if (m_st == 0 && start) begin nst = 1; m_dir = dir_read; end
      else if (m_st == 1 && blk_end) begin
        if (blk_remain <= 1) nst = 4;
        else if (stop_req) nst = (m_dir && rw_en) ? 3 : 2;
      end
      else if (paused_m && resume_m) nst = 1;
      else if (m_st == 4) nst = 0;
      m_gap = (m_st == 1) && blk_end && (blk_remain > 1);
      if (cont_set) m_cont = 1;
      else if (resume_m) m_cont = 0;
      m_st = nst;
    end
    #1;
    if (rst_n) begin
      chk(run == (m_st == 1), "R3 run", run, m_st == 1);
      chk(busy == (m_st == 1 || m_st == 4), "R2 busy", busy, m_st == 1 || m_st == 4);
      chk(clk_en == !(m_st == 2 && m_dir), "R4 clk_en", clk_en, !(m_st == 2 && m_dir));
      chk(read_wait_drv == (m_st == 3), "R5 read_wait_drv", read_wait_drv, m_st == 3);
      chk(irq_window == (gap_irq_en && bus_4bit && (m_gap || m_st == 2 || m_st == 3)),
          "R8 irq_window", irq_window, gap_irq_en && bus_4bit && (m_gap || m_st == 2 || m_st == 3));
      chk(xfer_done == (m_st == 4), "R9 xfer_done", xfer_done, m_st == 4);
      chk(cont_bit == m_cont, "R7 cont_bit", cont_bit, m_cont);
      chk(wr_accept == (data_wr && !stop_req), "R10 wr_accept", wr_accept, data_wr && !stop_req);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic end_block(input int rem);
    blk_remain = CNT_W'(rem); blk_end = 1;
    cyc(1);
    blk_end = 0;
  endtask

  task automatic pulse_cont();
    cont_set = 1; cyc(1); cont_set = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    #1;
    chk(!run && !busy && !read_wait_drv && !irq_window && !xfer_done && !cont_bit && clk_en,
        "R1 reset outputs", {run, busy, read_wait_drv, irq_window, xfer_done, cont_bit, clk_en}, 1);
    @(negedge clk); rst_n = 1;

    // write transfer, 4-bit, gap interrupts on
    gap_irq_en = 1; bus_4bit = 1; dir_read = 0;
    start = 1; cyc(1); start = 0; dir_read = 1;
    cyc(1); #1 chk(run, "R2 run after start", run, 1);
    @(negedge clk); end_block(3);
    cyc(2);
    stop_req = 1; data_wr = 1; cyc(1);
    #1 chk(!wr_accept, "R10 write rejected under stop", wr_accept, 0);
    @(negedge clk); data_wr = 0;
    cyc(2); #1 chk(run, "R3 mid-block stop ignored", run, 1);
    @(negedge clk); end_block(2);
    cyc(1); #1 chk(!run && clk_en, "R4 write pause keeps clock", {run, clk_en}, 1);
    @(negedge clk); pulse_cont(); cyc(3);
    #1 chk(!run, "R6 continue blocked by stop", run, 0);
    @(negedge clk); stop_req = 0;
    cyc(1); #1 chk(run && !cont_bit, "R7 continue cleared on resume", {run, cont_bit}, 2);
    @(negedge clk); data_wr = 1; cyc(1); data_wr = 0;
    cyc(2); end_block(1);
    #1 chk(xfer_done, "R9 done pulse", xfer_done, 1);
    @(negedge clk); cyc(1);

    // read with read-wait, final block with stop pending
    dir_read = 1; rw_en = 1;
    start = 1; cyc(1); start = 0;
    cyc(2); stop_req = 1; end_block(4);
    #1 chk(read_wait_drv && clk_en, "R5 read-wait drive", {read_wait_drv, clk_en}, 3);
    @(negedge clk); cyc(2); stop_req = 0; pulse_cont(); cyc(3);
    stop_req = 1; end_block(1);
    #1 chk(xfer_done && busy, "R9 done despite stop", {xfer_done, busy}, 3);
    @(negedge clk); stop_req = 0; cyc(2);

    // read without read-wait on a 1-bit bus
    rw_en = 0; bus_4bit = 0;
    start = 1; cyc(1); start = 0;
    cyc(1); end_block(5);
    #1 chk(!irq_window, "R8 no window on 1-bit gap", irq_window, 0);
    @(negedge clk); stop_req = 1; end_block(4);
    #1 chk(!clk_en && !read_wait_drv && !irq_window, "R4 clock halted",
           {clk_en, read_wait_drv, irq_window}, 0);
    @(negedge clk); bus_4bit = 1; cyc(1);
    #1 chk(irq_window, "R8 window during pause on 4-bit", irq_window, 1);
    @(negedge clk); stop_req = 0; cont_set = 1; cyc(1);
    cyc(1); cont_set = 0; cyc(1);
    #1 chk(run && cont_bit, "R7 set wins over clear", {run, cont_bit}, 3);
    @(negedge clk); end_block(0); cyc(2);
    #1 chk(!busy, "R9 idle after done", busy, 0);

    cyc(3);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule